// File: doc/BRIEF.md
# Three-Leg Bridge PWM Gate Sequencer with Braking

This block turns a commutation choice into the six gate enables of a three-leg power bridge. An external commutation stage names, with two one-hot selects, the leg whose high side is pulsed and the leg whose low side carries the return current. An internal period counter pulses the chosen high side at the start of every PWM period for a programmed number of clocks. During the rest of the period the same leg's low side conducts (synchronous rectification). An overcurrent input cuts the running on-pulse short until the next period begins.

Two braking modes replace normal drive. Shorted brake turns on all three low sides. E-brake pulses all three low sides together at a separately programmed duty. Fault inputs (undervoltage, overtemperature, stall, invalid position code) blank every gate for as long as any of them is high. A reversal of the direction input blanks all gates for one dead-time interval. Every leg has its own dead-time state machine, so no gate of a leg turns on until both gates of that leg have been off long enough, whatever the mode.

Top module: `bridge_gate_seq`

Mode state machine (`seq_mode_fsm`), one clocked state register, priority top to bottom:
- any fault input high: every state goes to SEQ_OFF.
- `dir_fwd` differs from its value one clock earlier: go to SEQ_BLANK, with the blank counter at 0.
- SEQ_BLANK: stay while the blank counter is below `dead_cyc`, then leave to the mode state.
- SEQ_OFF, SEQ_RUN, SEQ_SHORT, SEQ_EBRAKE: go to the mode state. The mode state is SEQ_SHORT if `short_brake` is high, else SEQ_EBRAKE if `ebrake_n` is low, else SEQ_RUN.

Leg state machine (`leg_dead_fsm`, one per leg):
- LEG_IDLE to LEG_HIGH: the high side is requested and the idle counter is at least `dead_cyc`.
- LEG_IDLE to LEG_LOW: the low side is requested and the idle counter is at least `dead_cyc`.
- LEG_HIGH to LEG_IDLE, and LEG_LOW to LEG_IDLE: the request drops.
- The idle counter counts the clocks spent in LEG_IDLE, saturates at its maximum, and is cleared in every other state.

## Requirements
- R1: While `rst_n` is low, and in the first clock after it rises, all six gate outputs are 0.
- R2: The period counter runs from 0 to `period_cyc`-1 and then wraps (`period_cyc` ≥ 2). Bit i of the selects and of the gate buses is leg i (0 = U, 1 = V, 2 = W). In run mode the high side of the `hi_sel` leg is requested while the count is below `duty_cyc`, and that leg's low side is requested at all other counts. The low side of the `lo_sel` leg is requested all the time. The third leg is requested nothing. With dead time T and T+2 ≤ D ≤ P−T−2, each period contains D−1−T high-side cycles, P−D−1−T rectifying low-side cycles and P return low-side cycles.
- R3: With `duty_cyc` = 0 the high side never turns on and its low side conducts every cycle. With `duty_cyc` ≥ `period_cyc` the high side conducts every cycle and its low side never turns on.
- R4: A gate changes one clock after its request changes. A gate turns on only after both gates of its leg have been off for `dead_cyc`+1 consecutive clocks. The two gates of a leg are never high in the same clock.
- R5: If `overcurrent` is high during a clock, the high-side request ends from that clock until the period counter wraps to 0. The next period has its full length.
- R6: With `short_brake` high, all three low sides are requested and no high side is.
- R7: With `ebrake_n` low and `short_brake` low, all three low sides are requested while the count is below `brake_duty_cyc`. With enough off time this gives `brake_duty_cyc` low cycles per period, over the range 0 to `period_cyc`. No high side is requested.
- R8: While any of `fault_uv`, `fault_ot`, `fault_stall`, `hall_bad` is high, all six gates are 0 from the clock after it rises. Normal drive resumes after all of them fall.
- R9: A change of `dir_fwd` withholds every request for `dead_cyc`+1 clocks. A low side that was on all the time is therefore off for exactly `dead_cyc`+1 clocks.
- R10: The order of priority is: fault, then direction blanking, then shorted brake, then E-brake, then run.
- R11: In run mode, nothing is requested if `hi_sel` or `lo_sel` is not one-hot, or if both name the same leg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_cyc | input | PERIOD_W | PWM period in clocks |
| duty_cyc | input | PERIOD_W | High-side on time in clocks |
| brake_duty_cyc | input | PERIOD_W | E-brake low-side on time in clocks |
| dead_cyc | input | DEAD_W | Dead time in clocks |
| hi_sel | input | 3 | One-hot leg whose high side is pulsed |
| lo_sel | input | 3 | One-hot leg whose low side returns current |
| dir_fwd | input | 1 | Direction; any change triggers blanking |
| overcurrent | input | 1 | Cycle-by-cycle current limit trip |
| short_brake | input | 1 | Shorted brake request |
| ebrake_n | input | 1 | E-brake request, active low |
| fault_uv | input | 1 | Undervoltage fault |
| fault_ot | input | 1 | Overtemperature fault |
| fault_stall | input | 1 | Stalled-rotor fault |
| hall_bad | input | 1 | Invalid position code |
| gate_hi | output | 3 | High-side gate enables, bit i = leg i |
| gate_lo | output | 3 | Low-side gate enables, bit i = leg i |

## Verification
The bench counts gate-high cycles over whole PWM periods, so any error of one cycle in the dead-time gap or in the duty comparison shows up as a wrong count. It drives the duty extremes 0, full period and above period. A design that compared against the period the wrong way would leave a gap or a stray pulse at those extremes. It trips the current limit part way through a pulse and checks both the cut-short pulse and a full pulse in the next period. A design that did not hold the trip would resume the pulse, and one that never cleared the trip would keep the next period short. It also reverses direction with both low sides on all the time, and checks that each drops for exactly the dead-time-plus-one window. It covers invalid or overlapping leg selects, each fault input, and fault and shorted brake held together against E-brake. A design with the priority wrong would drive gates there.

// File: rtl/gate_seq_pkg.sv
package gate_seq_pkg;

    localparam int NUM_LEGS = 3;

    typedef enum logic [2:0] {
        SEQ_OFF,
        SEQ_BLANK,
        SEQ_RUN,
        SEQ_SHORT,
        SEQ_EBRAKE
    } seq_state_e;

    typedef enum logic [1:0] {
        LEG_IDLE,
        LEG_HIGH,
        LEG_LOW
    } leg_state_e;

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int PERIOD_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] period_cyc,
    input  logic [PERIOD_W-1:0] duty_cyc,
    input  logic [PERIOD_W-1:0] brake_duty_cyc,
    input  logic                overcurrent,
    output logic                drive_on,
    output logic                brake_on
);

    logic [PERIOD_W-1:0] cnt;
    logic                oc_trip;
    logic                wrap;

    // wrap also catches a count left above a shortened period
    assign wrap = (cnt >= period_cyc - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            oc_trip <= 1'b0;
        end else begin
            cnt     <= wrap ? '0 : cnt + 1'b1;
            oc_trip <= wrap ? 1'b0 : (oc_trip | overcurrent);
        end
    end

    always_comb begin
        drive_on = (cnt < duty_cyc) && !oc_trip && !overcurrent;
        brake_on = (cnt < brake_duty_cyc);
    end

    // R5: a trip keeps the pulse off until the period restarts
    p_oc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(overcurrent) && cnt != '0) |-> !drive_on);

endmodule

// File: rtl/seq_mode_fsm.sv
module seq_mode_fsm
    import gate_seq_pkg::*;
#(
    parameter int DEAD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault_any,
    input  logic              dir_fwd,
    input  logic              short_brake,
    input  logic              ebrake_n,
    input  logic [DEAD_W-1:0] dead_cyc,
    output seq_state_e        state
);

    localparam logic [DEAD_W-1:0] BLANK_MAX = '1;

    seq_state_e        state_nx;
    seq_state_e        mode_st;
    logic              dir_q;
    logic              dir_chg;
    logic [DEAD_W-1:0] blank_cnt;

    assign dir_chg = (dir_fwd != dir_q);

    always_comb begin
        if (short_brake)
            mode_st = SEQ_SHORT;
        else if (!ebrake_n)
            mode_st = SEQ_EBRAKE;
        else
            mode_st = SEQ_RUN;
    end

    always_comb begin
        state_nx = state;
        if (fault_any) begin
            state_nx = SEQ_OFF;
        end else if (dir_chg) begin
            state_nx = SEQ_BLANK;
        end else begin
            unique case (state)
                SEQ_BLANK:  state_nx = (blank_cnt >= dead_cyc) ? mode_st : SEQ_BLANK;
                SEQ_OFF,
                SEQ_RUN,
                SEQ_SHORT,
                SEQ_EBRAKE: state_nx = mode_st;
                default:    state_nx = SEQ_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SEQ_OFF;
            dir_q     <= dir_fwd;
            blank_cnt <= '0;
        end else begin
            state <= state_nx;
            dir_q <= dir_fwd;
            if (dir_chg)
                blank_cnt <= '0;
            else if (state == SEQ_BLANK && blank_cnt != BLANK_MAX)
                blank_cnt <= blank_cnt + 1'b1;
            else if (state != SEQ_BLANK)
                blank_cnt <= '0;
        end
    end

    // R10: a fault overrides every other state one clock later
    p_fault_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fault_any |=> state == SEQ_OFF);

    // R9: a direction change without fault enters blanking
    p_dir_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_any && dir_fwd != $past(dir_fwd)) |=> state == SEQ_BLANK);

endmodule

// File: rtl/leg_dead_fsm.sv
module leg_dead_fsm
    import gate_seq_pkg::*;
#(
    parameter int DEAD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEAD_W-1:0] dead_cyc,
    input  logic              req_hi,
    input  logic              req_lo,
    output logic              gate_hi,
    output logic              gate_lo
);

    localparam logic [DEAD_W-1:0] IDLE_MAX = '1;

    leg_state_e        st;
    leg_state_e        st_nx;
    logic [DEAD_W-1:0] idle_cnt;
    logic              gap_ok;

    assign gap_ok = (idle_cnt >= dead_cyc);

    always_comb begin
        st_nx = st;
        unique case (st)
            LEG_IDLE: begin
                if (req_hi && gap_ok)
                    st_nx = LEG_HIGH;
                else if (req_lo && gap_ok)
                    st_nx = LEG_LOW;
            end
            LEG_HIGH: if (!req_hi) st_nx = LEG_IDLE;
            LEG_LOW:  if (!req_lo) st_nx = LEG_IDLE;
            default:  st_nx = LEG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= LEG_IDLE;
            idle_cnt <= '0;
        end else begin
            st <= st_nx;
            if (st != LEG_IDLE)
                idle_cnt <= '0;
            else if (idle_cnt != IDLE_MAX)
                idle_cnt <= idle_cnt + 1'b1;
        end
    end

    always_comb begin
        gate_hi = (st == LEG_HIGH);
        gate_lo = (st == LEG_LOW);
    end

    // R4: never both gates of one leg
    p_leg_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo));

    // R4: a turn-on is always preceded by an off clock of the partner
    p_hi_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_hi) |-> $past(!gate_lo));
    p_lo_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_lo) |-> $past(!gate_hi));

endmodule

// File: rtl/bridge_gate_seq.sv
module bridge_gate_seq
    import gate_seq_pkg::*;
#(
    parameter int PERIOD_W = 8,
    parameter int DEAD_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] period_cyc,
    input  logic [PERIOD_W-1:0] duty_cyc,
    input  logic [PERIOD_W-1:0] brake_duty_cyc,
    input  logic [DEAD_W-1:0]   dead_cyc,
    input  logic [2:0]          hi_sel,
    input  logic [2:0]          lo_sel,
    input  logic                dir_fwd,
    input  logic                overcurrent,
    input  logic                short_brake,
    input  logic                ebrake_n,
    input  logic                fault_uv,
    input  logic                fault_ot,
    input  logic                fault_stall,
    input  logic                hall_bad,
    output logic [2:0]          gate_hi,
    output logic [2:0]          gate_lo
);

    seq_state_e          state;
    logic                fault_any;
    logic                drive_on;
    logic                brake_on;
    logic                sel_ok;
    logic [NUM_LEGS-1:0] hi_req;
    logic [NUM_LEGS-1:0] lo_req;

    assign fault_any = fault_uv | fault_ot | fault_stall | hall_bad;
    assign sel_ok    = $onehot(hi_sel) && $onehot(lo_sel) && ((hi_sel & lo_sel) == 3'b000);

    pwm_timebase #(.PERIOD_W(PERIOD_W)) u_timebase (
        .clk            (clk),
        .rst_n          (rst_n),
        .period_cyc     (period_cyc),
        .duty_cyc       (duty_cyc),
        .brake_duty_cyc (brake_duty_cyc),
        .overcurrent    (overcurrent),
        .drive_on       (drive_on),
        .brake_on       (brake_on)
    );

    seq_mode_fsm #(.DEAD_W(DEAD_W)) u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .fault_any   (fault_any),
        .dir_fwd     (dir_fwd),
        .short_brake (short_brake),
        .ebrake_n    (ebrake_n),
        .dead_cyc    (dead_cyc),
        .state       (state)
    );

    // request decode; faults cut requests without waiting for the state
    always_comb begin
        hi_req = '0;
        lo_req = '0;
        if (!fault_any) begin
            unique case (state)
                SEQ_RUN: begin
                    if (sel_ok) begin
                        for (int i = 0; i < NUM_LEGS; i++) begin
                            hi_req[i] = hi_sel[i] && drive_on;
                            lo_req[i] = lo_sel[i] || (hi_sel[i] && !drive_on);
                        end
                    end
                end
                SEQ_SHORT:  lo_req = '1;
                SEQ_EBRAKE: lo_req = {NUM_LEGS{brake_on}};
                SEQ_OFF,
                SEQ_BLANK:  ;
                default:    ;
            endcase
        end
    end

    generate
        for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
            leg_dead_fsm #(.DEAD_W(DEAD_W)) u_leg (
                .clk      (clk),
                .rst_n    (rst_n),
                .dead_cyc (dead_cyc),
                .req_hi   (hi_req[g]),
                .req_lo   (lo_req[g]),
                .gate_hi  (gate_hi[g]),
                .gate_lo  (gate_lo[g])
            );
        end
    endgenerate

    // R4: decode never asks for both gates of a leg
    p_req_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_req & lo_req) == '0);

    // R8: any fault clears all gates by the next clock
    p_fault_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_any |=> (gate_hi == 3'b000 && gate_lo == 3'b000));

    // R6: high sides stay off once shorted brake has settled
    p_short_hi_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_SHORT && $past(state) == SEQ_SHORT) |-> gate_hi == 3'b000);

    // R7: high sides stay off in E-brake
    p_ebrake_hi_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_EBRAKE && $past(state) == SEQ_EBRAKE) |-> gate_hi == 3'b000);

    // R9: blanking empties the whole bridge
    p_blank_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_BLANK && $past(state) == SEQ_BLANK)
            |-> (gate_hi == 3'b000 && gate_lo == 3'b000));

endmodule

// File: tb/test_bridge_gate_seq.sv
module test_bridge_gate_seq;

    typedef struct packed {
        logic [7:0] per;
        logic [7:0] dut;
        logic [7:0] bdt;
        logic [3:0] dead;
        logic [2:0] hs;
        logic [2:0] ls;
        logic       sb;
        logic       ebn;
        logic [7:0] eh_u;
        logic [7:0] eh_v;
        logic [7:0] eh_w;
        logic [7:0] el_u;
        logic [7:0] el_v;
        logic [7:0] el_w;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 12;
    // expected counts are per PWM period
    localparam vec_t VECS [NV] = '{
        '{8'd20, 8'd10, 8'd0,  4'd3, 3'b001, 3'b010, 1'b0, 1'b1, 8'd6,  8'd0,  8'd0, 8'd6,  8'd20, 8'd0,  4'd2},  // R2
        '{8'd20, 8'd0,  8'd0,  4'd3, 3'b001, 3'b010, 1'b0, 1'b1, 8'd0,  8'd0,  8'd0, 8'd20, 8'd20, 8'd0,  4'd3},  // R3 duty 0
        '{8'd20, 8'd20, 8'd0,  4'd3, 3'b001, 3'b010, 1'b0, 1'b1, 8'd20, 8'd0,  8'd0, 8'd0,  8'd20, 8'd0,  4'd3},  // R3 full
        '{8'd20, 8'd25, 8'd0,  4'd3, 3'b001, 3'b010, 1'b0, 1'b1, 8'd20, 8'd0,  8'd0, 8'd0,  8'd20, 8'd0,  4'd3},  // R3 above period
        '{8'd10, 8'd5,  8'd0,  4'd0, 3'b100, 3'b001, 1'b0, 1'b1, 8'd0,  8'd0,  8'd4, 8'd10, 8'd0,  8'd4,  4'd4},  // R4 zero dead
        '{8'd20, 8'd14, 8'd0,  4'd3, 3'b010, 3'b100, 1'b0, 1'b1, 8'd0,  8'd10, 8'd0, 8'd0,  8'd2,  8'd20, 4'd2},  // R2
        '{8'd20, 8'd10, 8'd8,  4'd3, 3'b001, 3'b010, 1'b1, 1'b0, 8'd0,  8'd0,  8'd0, 8'd20, 8'd20, 8'd20, 4'd6},  // R6, R10 over E-brake
        '{8'd20, 8'd10, 8'd8,  4'd3, 3'b001, 3'b010, 1'b0, 1'b0, 8'd0,  8'd0,  8'd0, 8'd8,  8'd8,  8'd8,  4'd7},  // R7
        '{8'd20, 8'd10, 8'd0,  4'd3, 3'b001, 3'b010, 1'b0, 1'b0, 8'd0,  8'd0,  8'd0, 8'd0,  8'd0,  8'd0,  4'd7},  // R7 zero
        '{8'd20, 8'd10, 8'd20, 4'd3, 3'b001, 3'b010, 1'b0, 1'b0, 8'd0,  8'd0,  8'd0, 8'd20, 8'd20, 8'd20, 4'd7},  // R7 full
        '{8'd20, 8'd10, 8'd0,  4'd3, 3'b011, 3'b100, 1'b0, 1'b1, 8'd0,  8'd0,  8'd0, 8'd0,  8'd0,  8'd0,  4'd11}, // R11 not one-hot
        '{8'd20, 8'd10, 8'd0,  4'd3, 3'b010, 3'b010, 1'b0, 1'b1, 8'd0,  8'd0,  8'd0, 8'd0,  8'd0,  8'd0,  4'd11}  // R11 same leg
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] period_cyc = 8'd20;
    logic [7:0] duty_cyc = 8'd10;
    logic [7:0] brake_duty_cyc = 8'd0;
    logic [3:0] dead_cyc = 4'd3;
    logic [2:0] hi_sel = 3'b001;
    logic [2:0] lo_sel = 3'b010;
    logic       dir_fwd = 1'b0;
    logic       overcurrent = 1'b0;
    logic       short_brake = 1'b0;
    logic       ebrake_n = 1'b1;
    logic       fault_uv = 1'b0;
    logic       fault_ot = 1'b0;
    logic       fault_stall = 1'b0;
    logic       hall_bad = 1'b0;
    logic [2:0] gate_hi;
    logic [2:0] gate_lo;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    bridge_gate_seq i_bridge_gate_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .period_cyc     (period_cyc),
        .duty_cyc       (duty_cyc),
        .brake_duty_cyc (brake_duty_cyc),
        .dead_cyc       (dead_cyc),
        .hi_sel         (hi_sel),
        .lo_sel         (lo_sel),
        .dir_fwd        (dir_fwd),
        .overcurrent    (overcurrent),
        .short_brake    (short_brake),
        .ebrake_n       (ebrake_n),
        .fault_uv       (fault_uv),
        .fault_ot       (fault_ot),
        .fault_stall    (fault_stall),
        .hall_bad       (hall_bad),
        .gate_hi        (gate_hi),
        .gate_lo        (gate_lo)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_cfg(input int per, input int dut, input int dead);
        period_cyc     = 8'(per);
        duty_cyc       = 8'(dut);
        dead_cyc       = 4'(dead);
        hi_sel         = 3'b001;
        lo_sel         = 3'b010;
        short_brake    = 1'b0;
        ebrake_n       = 1'b1;
        repeat (3 * per + 40) @(negedge clk);
    endtask

    // counts cycles with gate_hi[0] high over four periods
    task automatic count_hi_u(input int per, output int c);
        c = 0;
        repeat (4 * per) begin
            @(negedge clk);
            c += int'(gate_hi[0]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int cu;
        // R1: reset state
        repeat (4) @(negedge clk);
        check("R1", "gates in reset", int'({gate_hi, gate_lo}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "gates first cycle after reset", int'({gate_hi, gate_lo}), 0);

        // table of steady-state vectors
        for (int v = 0; v < NV; v++) begin
            int ch [3];
            int cl [3];
            int eh [3];
            int el [3];
            string tag;
            period_cyc     = VECS[v].per;
            duty_cyc       = VECS[v].dut;
            brake_duty_cyc = VECS[v].bdt;
            dead_cyc       = VECS[v].dead;
            hi_sel         = VECS[v].hs;
            lo_sel         = VECS[v].ls;
            short_brake    = VECS[v].sb;
            ebrake_n       = VECS[v].ebn;
            eh = '{int'(VECS[v].eh_u), int'(VECS[v].eh_v), int'(VECS[v].eh_w)};
            el = '{int'(VECS[v].el_u), int'(VECS[v].el_v), int'(VECS[v].el_w)};
            tag = $sformatf("R%0d", VECS[v].req);
            repeat (3 * int'(VECS[v].per) + 40) @(negedge clk);
            for (int l = 0; l < 3; l++) begin
                ch[l] = 0;
                cl[l] = 0;
            end
            repeat (4 * int'(VECS[v].per)) begin
                @(negedge clk);
                for (int l = 0; l < 3; l++) begin
                    ch[l] += int'(gate_hi[l]);
                    cl[l] += int'(gate_lo[l]);
                end
            end
            for (int l = 0; l < 3; l++) begin
                check(tag, $sformatf("vec %0d high leg %0d", v, l), ch[l], 4 * eh[l]);
                check(tag, $sformatf("vec %0d low leg %0d", v, l), cl[l], 4 * el[l]);
            end
        end

        // R5: trip three cycles after the pulse starts
        run_cfg(20, 14, 3);
        @(negedge clk);
        while (gate_hi[0]) @(negedge clk);
        while (!gate_hi[0]) @(negedge clk);
        cu = 1;
        for (int i = 0; i < 20; i++) begin
            if (i > 0) begin
                @(negedge clk);
                cu += int'(gate_hi[0]);
            end
            if (i == 3) overcurrent = 1'b1;
            if (i == 4) overcurrent = 1'b0;
        end
        check("R5", "truncated pulse length", cu, 4);
        cu = 0;
        repeat (20) begin
            @(negedge clk);
            cu += int'(gate_hi[0]);
        end
        check("R5", "next period pulse length", cu, 10);

        // R8: each fault input blanks every gate
        for (int f = 0; f < 4; f++) begin
            int nz;
            run_cfg(20, 10, 3);
            case (f)
                0: fault_uv    = 1'b1;
                1: fault_ot    = 1'b1;
                2: fault_stall = 1'b1;
                default: hall_bad = 1'b1;
            endcase
            nz = 0;
            repeat (30) begin
                @(negedge clk);
                if ({gate_hi, gate_lo} != 6'd0) nz++;
            end
            check("R8", $sformatf("cycles with a gate on, fault %0d", f), nz, 0);
            fault_uv = 1'b0; fault_ot = 1'b0; fault_stall = 1'b0; hall_bad = 1'b0;
            repeat (100) @(negedge clk);
            count_hi_u(20, cu);
            check("R8", $sformatf("recovery after fault %0d", f), cu, 24);
        end

        // R10: fault beats shorted brake
        short_brake = 1'b1;
        fault_ot = 1'b1;
        repeat (10) @(negedge clk);
        cu = 0;
        repeat (40) begin
            @(negedge clk);
            cu += int'(gate_lo[0]) + int'(gate_lo[1]) + int'(gate_lo[2]);
        end
        check("R10", "low gates with fault and shorted brake", cu, 0);
        fault_ot = 1'b0;
        short_brake = 1'b0;

        // R9: reversal blanks a steadily-on low side for dead+1 clocks
        for (int d = 3; d >= 0; d -= 3) begin
            int off_ret;
            int off_rec;
            run_cfg(20, 0, d);
            dir_fwd = ~dir_fwd;
            off_ret = 0;
            off_rec = 0;
            repeat (20) begin
                @(negedge clk);
                off_ret += int'(!gate_lo[1]);
                off_rec += int'(!gate_lo[0]);
            end
            check("R9", $sformatf("return low off cycles, dead %0d", d), off_ret, d + 1);
            check("R9", $sformatf("rectifier low off cycles, dead %0d", d), off_rec, d + 1);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule